// File: doc/BRIEF.md
# Three-Dimension Crossbar Route Unit

This unit makes the routing decision at one node of a network where every line of nodes along a dimension shares one full crossbar, so one hop on a dimension reaches any coordinate on that line. Several input ports feed it flits. Each flit carries a two-bit type. Head and single-flit packets also carry a header with a destination coordinate, a broadcast flag, a broadcast stage and a partition number. For each accepted flit the unit produces, one cycle later, a route for that port. The route is a target bitmask per dimension crossbar plus a local-delivery bit.

Unicast packets settle the dimensions in the order X, Y, Z and skip any dimension whose coordinate already matches the node. A packet is delivered locally when all three coordinates match. Switching is wormhole: a head flit fixes the route, the body and tail flits of that packet reuse it, and a single-flit packet is routed from its own header.

A broadcast at stage s fans out on every dimension d >= s. Each copy sent along dimension d is meant to continue at stage d+1 at its receivers, so the spread covers one dimension before the next. Fan-out targets are limited to the node's partition box, which is given as inclusive low and high bounds per dimension. A broadcast tagged with a partition other than the node's own is dropped. Only one broadcast may be in flight through the unit at a time. A second broadcast is held back with a ready signal until the first one's tail has passed.

Top module: `xb_route_unit`

## Requirements
- R1: A unicast head or single flit whose X destination differs from `my_x` is routed to exactly bit `dx` of the X mask, with every other mask and the local bit clear.
- R2: A unicast whose X coordinate matches `my_x` is routed on Y to bit `dy` if Y differs. Otherwise it is routed on Z to bit `dz` if Z differs. Exactly one mask bit is set.
- R3: A unicast whose three coordinates all equal the node's own is routed to the local bit only.
- R4: Outputs are registered. A flit accepted at a clock edge appears at the outputs from that edge on, with its type code unchanged. Type codes are 00 head, 01 body, 10 tail and 11 single-flit packet. `out_valid` is low in a cycle that follows no accepted flit.
- R5: Body (01) and tail (10) flits take the route fixed by their packet's head flit. The header fields presented with them are ignored.
- R6: A single-flit packet (11) is routed from its own header in the cycle it is accepted.
- R7: A broadcast whose partition equals `my_part` sets the local bit. For every dimension d >= stage (X=0, Y=1, Z=2) it sets each coordinate i with lo <= i <= hi and i not equal to the node's own coordinate. Dimensions below the stage stay clear, and stage 3 gives local delivery only.
- R8: A broadcast whose partition differs from `my_part` is accepted and emitted with all masks and the local bit clear.
- R9: After a broadcast head (00) is accepted, any broadcast head or single flit on another port sees `in_ready` low and is not taken. This lasts until the cycle after that broadcast's tail is accepted.
- R10: When the lock is free and several ports present broadcast heads or single flits in the same cycle, only the lowest-numbered port is ready.
- R11: Unicast flits, and body and tail flits of any packet, are always ready.
- R12: During and right after reset, `out_valid` and `out_local` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| my_x | input | 3 | Node X coordinate |
| my_y | input | 5 | Node Y coordinate |
| my_z | input | 4 | Node Z coordinate |
| my_part | input | 4 | Node partition number |
| lo_x | input | 3 | Partition low X bound |
| hi_x | input | 3 | Partition high X bound |
| lo_y | input | 5 | Partition low Y bound |
| hi_y | input | 5 | Partition high Y bound |
| lo_z | input | 4 | Partition low Z bound |
| hi_z | input | 4 | Partition high Z bound |
| in_valid | input | 4 | Flit present, per port |
| in_type | input | 4x2 | Flit type per port |
| in_bcast | input | 4 | Broadcast flag per port |
| in_stage | input | 4x2 | Broadcast stage per port |
| in_part | input | 4x4 | Packet partition per port |
| in_dx | input | 4x3 | Destination X per port |
| in_dy | input | 4x5 | Destination Y per port |
| in_dz | input | 4x4 | Destination Z per port |
| in_ready | output | 4 | Flit accepted this cycle if valid |
| out_valid | output | 4 | Routed flit present, per port |
| out_type | output | 4x2 | Routed flit type |
| out_local | output | 4 | Deliver to this node |
| out_mask_x | output | 4x8 | X crossbar targets |
| out_mask_y | output | 4x17 | Y crossbar targets |
| out_mask_z | output | 4x16 | Z crossbar targets |

## Verification
The assertions assume well-formed packets on every port: a head, then bodies, then a tail, or a lone single flit, with no body or tail flit outside a packet. They also assume destination coordinates within each dimension's size, and the node's own coordinate inside its partition box. The stimulus builds every packet through tasks that issue a head, zero to two bodies and a tail, or one single flit. Coordinates are drawn only from each dimension's range, with about half of them forced equal to the node's own so that dimension skipping is exercised. Random packets go to one port at a time, so the lock is always free at their heads. Contention is produced only in directed sequences.

// File: rtl/xb_route_pkg.sv
// Package: shared flit type codes and default network geometry.
// Assumes: two-bit flit type field on every port.
package xb_route_pkg;
    typedef enum logic [1:0] {
        FL_HEAD = 2'b00,
        FL_BODY = 2'b01,
        FL_TAIL = 2'b10,
        FL_SOLO = 2'b11
    } flit_e;

    localparam int DEF_DX = 8;
    localparam int DEF_DY = 17;
    localparam int DEF_DZ = 16;
endpackage

// File: rtl/xb_route_calc.sv
// Module: combinational route decision for one header.
// Unicast goes X, then Y, then Z, skipping matching dimensions; a full
// match means local delivery. Broadcast fans out on all dimensions at or
// above its stage, within the partition box and excluding the node itself.
// Assumes destination and bounds lie inside each dimension's size.
module xb_route_calc #(
    parameter int DX = 8,
    parameter int DY = 17,
    parameter int DZ = 16,
    parameter int PW = 4,
    parameter int XW = $clog2(DX),
    parameter int YW = $clog2(DY),
    parameter int ZW = $clog2(DZ)
) (
    input  logic [XW-1:0] my_x,
    input  logic [YW-1:0] my_y,
    input  logic [ZW-1:0] my_z,
    input  logic [PW-1:0] my_part,
    input  logic [XW-1:0] lo_x,
    input  logic [XW-1:0] hi_x,
    input  logic [YW-1:0] lo_y,
    input  logic [YW-1:0] hi_y,
    input  logic [ZW-1:0] lo_z,
    input  logic [ZW-1:0] hi_z,
    input  logic          bcast,
    input  logic [1:0]    stage,
    input  logic [PW-1:0] part,
    input  logic [XW-1:0] dx,
    input  logic [YW-1:0] dy,
    input  logic [ZW-1:0] dz,
    output logic          rt_local,
    output logic [DX-1:0] rt_mx,
    output logic [DY-1:0] rt_my,
    output logic [DZ-1:0] rt_mz
);
    logic [DX-1:0] span_x;
    logic [DY-1:0] span_y;
    logic [DZ-1:0] span_z;

    // Partition fan-out spans per dimension, own coordinate removed.
    always_comb begin
        for (int i = 0; i < DX; i++)
            span_x[i] = (i >= int'(lo_x)) && (i <= int'(hi_x)) && (i != int'(my_x));
        for (int i = 0; i < DY; i++)
            span_y[i] = (i >= int'(lo_y)) && (i <= int'(hi_y)) && (i != int'(my_y));
        for (int i = 0; i < DZ; i++)
            span_z[i] = (i >= int'(lo_z)) && (i <= int'(hi_z)) && (i != int'(my_z));
    end

    // Route selection for unicast or broadcast headers.
    always_comb begin
        rt_local = 1'b0;
        rt_mx    = '0;
        rt_my    = '0;
        rt_mz    = '0;
        if (!bcast) begin
            if (dx != my_x) begin
                if (int'(dx) < DX) rt_mx[dx] = 1'b1;
            end else if (dy != my_y) begin
                if (int'(dy) < DY) rt_my[dy] = 1'b1;
            end else if (dz != my_z) begin
                if (int'(dz) < DZ) rt_mz[dz] = 1'b1;
            end else begin
                rt_local = 1'b1;
            end
        end else if (part == my_part) begin
            rt_local = 1'b1;
            if (stage == 2'd0) rt_mx = span_x;
            if (stage <= 2'd1) rt_my = span_y;
            if (stage <= 2'd2) rt_mz = span_z;
        end
    end
endmodule

// File: rtl/xb_bcast_lock.sv
// Module: single lock serialising broadcasts across input ports.
// A broadcast head or single flit needs a grant; the lowest requesting port
// wins while the lock is free. A granted head holds the lock until its
// owner's tail is accepted. Assumes NP >= 2 and well-formed packets.
module xb_bcast_lock #(
    parameter int NP = 4,
    parameter int OW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] req,
    input  logic [NP-1:0] req_head,
    input  logic [NP-1:0] acc_tail,
    output logic [NP-1:0] grant
);
    logic          busy;
    logic [OW-1:0] owner;
    logic [OW-1:0] win_idx;
    logic          win_any;

    // Fixed-priority pick of the lowest requesting port.
    always_comb begin
        win_any = 1'b0;
        win_idx = '0;
        for (int p = NP - 1; p >= 0; p--) begin
            if (req[p]) begin
                win_any = 1'b1;
                win_idx = OW'(p);
            end
        end
    end

    // Grant only while no broadcast is in flight.
    always_comb begin
        grant = '0;
        if (!busy && win_any) grant[win_idx] = 1'b1;
    end

    // Lock state: taken by a granted head, freed by the owner's tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            owner <= '0;
        end else if (busy) begin
            if (acc_tail[owner]) busy <= 1'b0;
        end else if (|(grant & req_head)) begin
            busy  <= 1'b1;
            owner <= win_idx;
        end
    end
endmodule

// File: rtl/xb_port_ctx.sv
// Module: per-port wormhole context and output register.
// Keeps the head's route for the body and tail of the packet; a single flit
// uses its freshly computed route. Assumes well-formed packet sequences.
module xb_port_ctx #(
    parameter int DX = 8,
    parameter int DY = 17,
    parameter int DZ = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic [1:0]    ftype,
    input  logic          rt_local,
    input  logic [DX-1:0] rt_mx,
    input  logic [DY-1:0] rt_my,
    input  logic [DZ-1:0] rt_mz,
    output logic          out_valid,
    output logic [1:0]    out_type,
    output logic          out_local,
    output logic [DX-1:0] out_mask_x,
    output logic [DY-1:0] out_mask_y,
    output logic [DZ-1:0] out_mask_z
);
    import xb_route_pkg::*;

    logic          hold_local;
    logic [DX-1:0] hold_mx;
    logic [DY-1:0] hold_my;
    logic [DZ-1:0] hold_mz;
    logic          use_fresh;

    // Head and single flits route from the header; others reuse the hold.
    assign use_fresh = (ftype == FL_HEAD) || (ftype == FL_SOLO);

    // Capture the route when a head flit is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_local <= 1'b0;
            hold_mx    <= '0;
            hold_my    <= '0;
            hold_mz    <= '0;
        end else if (acc && ftype == FL_HEAD) begin
            hold_local <= rt_local;
            hold_mx    <= rt_mx;
            hold_my    <= rt_my;
            hold_mz    <= rt_mz;
        end
    end

    // Output register for the routed flit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_type   <= 2'b00;
            out_local  <= 1'b0;
            out_mask_x <= '0;
            out_mask_y <= '0;
            out_mask_z <= '0;
        end else begin
            out_valid <= acc;
            if (acc) begin
                out_type   <= ftype;
                out_local  <= use_fresh ? rt_local : hold_local;
                out_mask_x <= use_fresh ? rt_mx : hold_mx;
                out_mask_y <= use_fresh ? rt_my : hold_my;
                out_mask_z <= use_fresh ? rt_mz : hold_mz;
            end
        end
    end
endmodule

// File: rtl/xb_route_unit.sv
// Module: top of the per-node route unit for a three-dimension crossbar
// network. NP input ports each get a route calculator and a wormhole
// context; one lock serialises broadcasts. Assumes node coordinate inside
// its partition box and the downstream crossbars always accept a flit.
module xb_route_unit #(
    parameter int NP = 4,
    parameter int DX = xb_route_pkg::DEF_DX,
    parameter int DY = xb_route_pkg::DEF_DY,
    parameter int DZ = xb_route_pkg::DEF_DZ,
    parameter int PW = 4,
    parameter int XW = $clog2(DX),
    parameter int YW = $clog2(DY),
    parameter int ZW = $clog2(DZ)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [XW-1:0]          my_x,
    input  logic [YW-1:0]          my_y,
    input  logic [ZW-1:0]          my_z,
    input  logic [PW-1:0]          my_part,
    input  logic [XW-1:0]          lo_x,
    input  logic [XW-1:0]          hi_x,
    input  logic [YW-1:0]          lo_y,
    input  logic [YW-1:0]          hi_y,
    input  logic [ZW-1:0]          lo_z,
    input  logic [ZW-1:0]          hi_z,
    input  logic [NP-1:0]          in_valid,
    input  logic [NP-1:0][1:0]     in_type,
    input  logic [NP-1:0]          in_bcast,
    input  logic [NP-1:0][1:0]     in_stage,
    input  logic [NP-1:0][PW-1:0]  in_part,
    input  logic [NP-1:0][XW-1:0]  in_dx,
    input  logic [NP-1:0][YW-1:0]  in_dy,
    input  logic [NP-1:0][ZW-1:0]  in_dz,
    output logic [NP-1:0]          in_ready,
    output logic [NP-1:0]          out_valid,
    output logic [NP-1:0][1:0]     out_type,
    output logic [NP-1:0]          out_local,
    output logic [NP-1:0][DX-1:0]  out_mask_x,
    output logic [NP-1:0][DY-1:0]  out_mask_y,
    output logic [NP-1:0][DZ-1:0]  out_mask_z
);
    import xb_route_pkg::*;

    logic [NP-1:0] req;
    logic [NP-1:0] req_head;
    logic [NP-1:0] acc_tail;
    logic [NP-1:0] grant;
    logic [NP-1:0] acc;

    xb_bcast_lock #(.NP(NP)) lock_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_head (req_head),
        .acc_tail (acc_tail),
        .grant    (grant)
    );

    for (genvar p = 0; p < NP; p++) begin : g_port
        logic          rt_local;
        logic [DX-1:0] rt_mx;
        logic [DY-1:0] rt_my;
        logic [DZ-1:0] rt_mz;

        // Lock request, readiness and acceptance for this port.
        always_comb begin
            req[p]      = in_valid[p] && in_bcast[p] &&
                          (in_type[p] == FL_HEAD || in_type[p] == FL_SOLO);
            req_head[p] = req[p] && (in_type[p] == FL_HEAD);
            in_ready[p] = !req[p] || grant[p];
            acc[p]      = in_valid[p] && in_ready[p];
            acc_tail[p] = acc[p] && (in_type[p] == FL_TAIL);
        end

        xb_route_calc #(.DX(DX), .DY(DY), .DZ(DZ), .PW(PW)) calc_i (
            .my_x     (my_x),
            .my_y     (my_y),
            .my_z     (my_z),
            .my_part  (my_part),
            .lo_x     (lo_x),
            .hi_x     (hi_x),
            .lo_y     (lo_y),
            .hi_y     (hi_y),
            .lo_z     (lo_z),
            .hi_z     (hi_z),
            .bcast    (in_bcast[p]),
            .stage    (in_stage[p]),
            .part     (in_part[p]),
            .dx       (in_dx[p]),
            .dy       (in_dy[p]),
            .dz       (in_dz[p]),
            .rt_local (rt_local),
            .rt_mx    (rt_mx),
            .rt_my    (rt_my),
            .rt_mz    (rt_mz)
        );

        xb_port_ctx #(.DX(DX), .DY(DY), .DZ(DZ)) ctx_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .acc        (acc[p]),
            .ftype      (in_type[p]),
            .rt_local   (rt_local),
            .rt_mx      (rt_mx),
            .rt_my      (rt_my),
            .rt_mz      (rt_mz),
            .out_valid  (out_valid[p]),
            .out_type   (out_type[p]),
            .out_local  (out_local[p]),
            .out_mask_x (out_mask_x[p]),
            .out_mask_y (out_mask_y[p]),
            .out_mask_z (out_mask_z[p])
        );
    end
endmodule

// File: rtl/xb_route_unit_chk.sv
// Module: assertion checker bound to the route unit.
// Assumes well-formed packets and in-range coordinates on every port.
module xb_route_unit_chk #(
    parameter int NP = 4,
    parameter int DX = 8,
    parameter int DY = 17,
    parameter int DZ = 16,
    parameter int PW = 4,
    parameter int XW = $clog2(DX),
    parameter int YW = $clog2(DY),
    parameter int ZW = $clog2(DZ)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [XW-1:0]          my_x,
    input logic [YW-1:0]          my_y,
    input logic [ZW-1:0]          my_z,
    input logic [NP-1:0]          in_valid,
    input logic [NP-1:0][1:0]     in_type,
    input logic [NP-1:0]          in_bcast,
    input logic [NP-1:0]          in_ready,
    input logic [NP-1:0]          out_valid,
    input logic [NP-1:0][1:0]     out_type,
    input logic [NP-1:0]          out_local,
    input logic [NP-1:0][DX-1:0]  out_mask_x,
    input logic [NP-1:0][DY-1:0]  out_mask_y,
    input logic [NP-1:0][DZ-1:0]  out_mask_z
);
    import xb_route_pkg::*;

    logic [NP-1:0] bc_taken;

    // Broadcast heads or single flits taken this cycle.
    always_comb begin
        for (int p = 0; p < NP; p++)
            bc_taken[p] = in_valid[p] && in_ready[p] && in_bcast[p] &&
                          (in_type[p] == FL_HEAD || in_type[p] == FL_SOLO);
    end

    p_one_bcast_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bc_taken));

    for (genvar p = 0; p < NP; p++) begin : g_chk
        p_uni_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[p] && in_ready[p] && !in_bcast[p] &&
             (in_type[p] == FL_HEAD || in_type[p] == FL_SOLO))
            |=> (out_valid[p] &&
                 $countones({out_local[p], out_mask_x[p], out_mask_y[p], out_mask_z[p]}) == 1));

        p_hold_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[p] && $past(out_valid[p]) &&
             (out_type[p] == FL_BODY || out_type[p] == FL_TAIL))
            |-> ($stable(out_mask_x[p]) && $stable(out_mask_y[p]) &&
                 $stable(out_mask_z[p]) && $stable(out_local[p])));

        p_no_self_r7: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[p] |-> (!out_mask_x[p][my_x] && !out_mask_y[p][my_y] &&
                              !out_mask_z[p][my_z]));

        p_ready_plain_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[p] && (!in_bcast[p] || in_type[p] == FL_BODY ||
                             in_type[p] == FL_TAIL)) |-> in_ready[p]);
    end
endmodule

bind xb_route_unit xb_route_unit_chk #(
    .NP(NP), .DX(DX), .DY(DY), .DZ(DZ), .PW(PW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .my_x       (my_x),
    .my_y       (my_y),
    .my_z       (my_z),
    .in_valid   (in_valid),
    .in_type    (in_type),
    .in_bcast   (in_bcast),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_type   (out_type),
    .out_local  (out_local),
    .out_mask_x (out_mask_x),
    .out_mask_y (out_mask_y),
    .out_mask_z (out_mask_z)
);

// File: tb/xb_route_unit_tb_top.sv
// Bench: directed corner cases plus seeded random packets, checked against
// a route model written from the requirements.
module xb_route_unit_tb_top;
    import xb_route_pkg::*;

    localparam int NP = 4;
    localparam int DX = 8;
    localparam int DY = 17;
    localparam int DZ = 16;
    localparam int PW = 4;
    localparam int MX = 3;
    localparam int MY = 9;
    localparam int MZ = 5;
    localparam int MP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] my_x = 3'(MX);
    logic [4:0] my_y = 5'(MY);
    logic [3:0] my_z = 4'(MZ);
    logic [3:0] my_part = 4'(MP);
    logic [2:0] lo_x = 3'd1, hi_x = 3'd6;
    logic [4:0] lo_y = 5'd4, hi_y = 5'd12;
    logic [3:0] lo_z = 4'd0, hi_z = 4'd15;
    logic [NP-1:0]         in_valid = '0;
    logic [NP-1:0][1:0]    in_type  = '0;
    logic [NP-1:0]         in_bcast = '0;
    logic [NP-1:0][1:0]    in_stage = '0;
    logic [NP-1:0][3:0]    in_part  = '0;
    logic [NP-1:0][2:0]    in_dx    = '0;
    logic [NP-1:0][4:0]    in_dy    = '0;
    logic [NP-1:0][3:0]    in_dz    = '0;
    logic [NP-1:0]         in_ready;
    logic [NP-1:0]         out_valid;
    logic [NP-1:0][1:0]    out_type;
    logic [NP-1:0]         out_local;
    logic [NP-1:0][DX-1:0] out_mask_x;
    logic [NP-1:0][DY-1:0] out_mask_y;
    logic [NP-1:0][DZ-1:0] out_mask_z;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xb_route_unit #(.NP(NP), .DX(DX), .DY(DY), .DZ(DZ), .PW(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y), .my_z(my_z),
        .my_part(my_part), .lo_x(lo_x), .hi_x(hi_x), .lo_y(lo_y), .hi_y(hi_y),
        .lo_z(lo_z), .hi_z(hi_z), .in_valid(in_valid), .in_type(in_type),
        .in_bcast(in_bcast), .in_stage(in_stage), .in_part(in_part),
        .in_dx(in_dx), .in_dy(in_dy), .in_dz(in_dz), .in_ready(in_ready),
        .out_valid(out_valid), .out_type(out_type), .out_local(out_local),
        .out_mask_x(out_mask_x), .out_mask_y(out_mask_y), .out_mask_z(out_mask_z)
    );

    // Expected route {local, X, Y, Z} from the requirements.
    function automatic logic [41:0] exp_route(input logic b, input int st,
                                              input int pt, input int dx,
                                              input int dy, input int dz);
        logic l = 1'b0;
        logic [7:0] mx = '0;
        logic [16:0] my = '0;
        logic [15:0] mz = '0;
        if (!b) begin
            if (dx != MX) mx[dx] = 1'b1;
            else if (dy != MY) my[dy] = 1'b1;
            else if (dz != MZ) mz[dz] = 1'b1;
            else l = 1'b1;
        end else if (pt == MP) begin
            l = 1'b1;
            for (int i = 0; i < DX; i++) if (st == 0 && i >= 1 && i <= 6 && i != MX) mx[i] = 1'b1;
            for (int i = 0; i < DY; i++) if (st <= 1 && i >= 4 && i <= 12 && i != MY) my[i] = 1'b1;
            for (int i = 0; i < DZ; i++) if (st <= 2 && i != MZ) mz[i] = 1'b1;
        end
        return {l, mx, my, mz};
    endfunction

    function automatic logic [41:0] got(input int p);
        return {out_local[p], out_mask_x[p], out_mask_y[p], out_mask_z[p]};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_flit(input int p, input logic [1:0] t, input logic b,
                            input int st, input int pt, input int dx,
                            input int dy, input int dz);
        in_valid[p] = 1'b1;
        in_type[p]  = t;
        in_bcast[p] = b;
        in_stage[p] = 2'(st);
        in_part[p]  = 4'(pt);
        in_dx[p]    = 3'(dx);
        in_dy[p]    = 5'(dy);
        in_dz[p]    = 4'(dz);
    endtask

    // Drive one flit just after a falling edge, then check it one edge later.
    task automatic one_flit(input int p, input logic [1:0] t, input logic b,
                            input int st, input int pt, input int dx, input int dy,
                            input int dz, input logic [41:0] e, input string tag);
        set_flit(p, t, b, st, pt, dx, dy, dz);
        #1;
        check(in_ready[p] == 1'b1, "R11", 64'(in_ready), 64'(1 << p));
        @(negedge clk);
        in_valid = '0;
        #1;
        check(out_valid[p] && out_type[p] == t && got(p) == e, tag,
              {out_valid[p], out_type[p], got(p)}, {1'b1, t, e});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == '0 && out_local == '0, "R12", 64'(out_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(out_valid == '0 && in_ready == '1, "R12", {out_valid, in_ready}, {4'd0, 4'hf});

        // R4: output absent before the edge, present after it.
        set_flit(0, FL_SOLO, 1'b0, 0, MP, 6, 0, 0);
        #1;
        check(out_valid[0] == 1'b0, "R4", 64'(out_valid), 64'd0);
        @(negedge clk);
        in_valid = '0;
        #1;
        check(out_valid[0] && out_type[0] == FL_SOLO && got(0) == exp_route(1'b0, 0, MP, 6, 0, 0),
              "R4", got(0), exp_route(1'b0, 0, MP, 6, 0, 0));
        @(negedge clk);
        #1;
        check(out_valid[0] == 1'b0, "R4", 64'(out_valid), 64'd0);

        // R3, R2 directed unicasts.
        one_flit(1, FL_SOLO, 1'b0, 0, MP, MX, MY, MZ, exp_route(1'b0, 0, MP, MX, MY, MZ), "R3");
        one_flit(1, FL_SOLO, 1'b0, 0, MP, MX, 16, 0, exp_route(1'b0, 0, MP, MX, 16, 0), "R2");
        one_flit(1, FL_SOLO, 1'b0, 0, MP, MX, MY, 15, exp_route(1'b0, 0, MP, MX, MY, 15), "R2");
        // R7 stage 3 local only, stage 1 skips X; R8 foreign partition.
        one_flit(2, FL_SOLO, 1'b1, 3, MP, 0, 0, 0, exp_route(1'b1, 3, MP, 0, 0, 0), "R7");
        one_flit(2, FL_SOLO, 1'b1, 1, MP, 0, 0, 0, exp_route(1'b1, 1, MP, 0, 0, 0), "R7");
        one_flit(2, FL_SOLO, 1'b1, 0, 7, 0, 0, 0, 42'd0, "R8");

        // R9: broadcast in flight on port 1 blocks port 2.
        set_flit(1, FL_HEAD, 1'b1, 0, MP, 0, 0, 0);
        #1;
        check(in_ready[1], "R9", 64'(in_ready), 64'h2);
        @(negedge clk);
        set_flit(1, FL_BODY, 1'b0, 2, 0, 7, 3, 3);
        set_flit(2, FL_SOLO, 1'b1, 2, MP, 0, 0, 0);
        #1;
        check(!in_ready[2] && in_ready[1], "R9", 64'(in_ready), 64'h2);
        @(negedge clk);
        set_flit(1, FL_TAIL, 1'b0, 1, 0, 5, 5, 5);
        #1;
        check(!in_ready[2] && out_valid[2] == 1'b0, "R9", {in_ready, out_valid}, 64'h20);
        @(negedge clk);
        in_valid[1] = 1'b0;
        #1;
        check(in_ready[2], "R9", 64'(in_ready), 64'h4);
        check(out_valid[1] && out_type[1] == FL_TAIL && got(1) == exp_route(1'b1, 0, MP, 0, 0, 0),
              "R5", got(1), exp_route(1'b1, 0, MP, 0, 0, 0));
        @(negedge clk);
        in_valid = '0;
        #1;
        check(out_valid[2] && got(2) == exp_route(1'b1, 2, MP, 0, 0, 0), "R9",
              got(2), exp_route(1'b1, 2, MP, 0, 0, 0));

        // R10: simultaneous broadcast heads, lowest port wins; R11 unicast passes.
        set_flit(0, FL_HEAD, 1'b1, 1, MP, 0, 0, 0);
        set_flit(3, FL_HEAD, 1'b1, 2, MP, 0, 0, 0);
        set_flit(1, FL_SOLO, 1'b0, 0, MP, 2, 0, 0);
        #1;
        check(in_ready[0] && !in_ready[3], "R10", 64'(in_ready), 64'h7);
        check(in_ready[1], "R11", 64'(in_ready), 64'h7);
        @(negedge clk);
        in_valid[1] = 1'b0;
        set_flit(0, FL_TAIL, 1'b0, 0, 0, 0, 0, 0);
        #1;
        check(!in_ready[3], "R10", 64'(in_ready), 64'h7);
        @(negedge clk);
        in_valid[0] = 1'b0;
        #1;
        check(in_ready[3], "R10", 64'(in_ready), 64'h8);
        @(negedge clk);
        set_flit(3, FL_TAIL, 1'b0, 0, 0, 1, 1, 1);
        #1;
        check(out_valid[3] && out_type[3] == FL_HEAD && got(3) == exp_route(1'b1, 2, MP, 0, 0, 0),
              "R10", got(3), exp_route(1'b1, 2, MP, 0, 0, 0));
        @(negedge clk);
        in_valid = '0;
        #1;

        // Random packets, one port at a time.
        for (int k = 0; k < 300; k++) begin
            int p = $urandom_range(0, NP - 1);
            logic b = ($urandom_range(0, 9) < 3);
            int st = $urandom_range(0, 3);
            int pt = ($urandom_range(0, 7) == 0) ? 1 : MP;
            int dx = $urandom_range(0, 1) ? MX : $urandom_range(0, DX - 1);
            int dy = $urandom_range(0, 1) ? MY : $urandom_range(0, DY - 1);
            int dz = $urandom_range(0, 1) ? MZ : $urandom_range(0, DZ - 1);
            logic [41:0] e = exp_route(b, st, pt, dx, dy, dz);
            string tag;
            if (b) tag = (pt == MP) ? "R7" : "R8";
            else if (dx != MX) tag = "R1";
            else if (dy != MY || dz != MZ) tag = "R2";
            else tag = "R3";
            if ($urandom_range(0, 1) == 1) begin
                one_flit(p, FL_SOLO, b, st, pt, dx, dy, dz, e, (k % 2 == 0) ? "R6" : tag);
            end else begin
                int nb = $urandom_range(0, 2);
                one_flit(p, FL_HEAD, b, st, pt, dx, dy, dz, e, tag);
                for (int j = 0; j < nb; j++)
                    one_flit(p, FL_BODY, ~b, $urandom_range(0, 3), $urandom_range(0, 15),
                             $urandom_range(0, 7), $urandom_range(0, 16),
                             $urandom_range(0, 15), e, "R5");
                one_flit(p, FL_TAIL, ~b, $urandom_range(0, 3), $urandom_range(0, 15),
                         $urandom_range(0, 7), $urandom_range(0, 16),
                         $urandom_range(0, 15), e, "R5");
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule